// File: doc/BRIEF.md
# Interleaved Voxel Octet Address Mapper

This block turns the base corner of a 2x2x2 voxel octet, given as global coordinates in a cubic volume, into eight in-bank addresses, one per voxel memory bank. The eight voxels of any octet always have distinct coordinate parities, so each lands in a different bank. A trilinear interpolator can therefore read the whole octet in a single memory cycle. The volume is cut into equal subcubes that are dealt round-robin to the processors of a ring. Each processor stores only its own subcubes, packed in a dense local numbering, and within a subcube voxels are grouped in 2x2x2 supervoxels.

For every axis the block works out the subcube coordinate and the local supervoxel coordinate. It then forms the local subcube number and checks that this processor owns the subcube. On an axis with an odd base, banks that hold the upper voxel take the next supervoxel. Beside each address the block reports which octet corner that bank supplies. An error flag marks octets that this processor cannot serve: either the subcube belongs to another processor, or the octet crosses the far face of the subcube. The mapping is a three-stage pipeline that accepts one octet per cycle.

Top module: `vx_octet_mapper`

## Requirements
- R1: A request presented with `in_vld` high at a rising edge produces `out_vld` high, together with its addresses, corner codes and error flag, exactly three rising edges later. One request is accepted on every cycle.
- R2: Bank index b has bit 0 = x parity, bit 1 = y parity and bit 2 = z parity of the voxel it holds. `bank_slot[b]` is the corner code {dz,dy,dx}, where dx = b[0] xor base_x[0], and likewise for y and z.
- R3: A bank address is {local subcube number (8 bits), z supervoxel (3 bits), y supervoxel (3 bits), x supervoxel (3 bits)}, 17 bits in total with default parameters.
- R4: The supervoxel coordinate on an axis is (coordinate mod 16) div 2, where 16 is the default subcube edge (volume edge divided by ring size times interleave).
- R5: On an axis where the base is even, all banks use the base's supervoxel coordinate. Where the base is odd, banks with that axis's parity bit 1 use the base value and banks with parity bit 0 use the base value plus one.
- R6: The local subcube number is (xs + 16*ys + 256*zs) div 16, where xs, ys, zs are the coordinates divided by 16.
- R7: `out_err` is 1 when (xs + ys + zs) mod 16 differs from `node_id`.
- R8: `out_err` is 1 when any axis has an odd base whose coordinate mod 16 equals 15, because the octet then crosses into a neighbouring subcube.
- R9: After a cycle with `rst` high, `out_vld` and `out_err` are 0, and requests already in flight are dropped.
- R10: `out_err` is never 1 while `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Octet request valid |
| base_x | input | 8 | Base x coordinate |
| base_y | input | 8 | Base y coordinate |
| base_z | input | 8 | Base z coordinate |
| node_id | input | 4 | This processor's index in the ring |
| out_vld | output | 1 | Result valid |
| out_err | output | 1 | Octet not servable locally |
| bank_addr | output | 8x17 | In-bank address, element b for bank b |
| bank_slot | output | 8x3 | Corner code {dz,dy,dx} supplied by bank b |

## Verification
Every result, including the addresses, corner codes and error flag, is due three rising edges after the edge that takes the request. The bench drives at falling edges and feeds one request per cycle. It compares request i against the outputs at the falling edge that follows the third rising edge after it, so streaming and isolated requests both use the same fixed offset. A single-cycle request checks that `out_vld` rises on exactly that edge and falls one cycle later. A reset applied with requests in flight checks that they are dropped.

// File: rtl/vxm_pkg.sv
package vxm_pkg;

   function automatic int unsigned vxm_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

   function automatic bit vxm_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   localparam int unsigned VXM_AXES  = 3;
   localparam int unsigned VXM_BANKS = 8;

endpackage

// File: rtl/vxm_axis_split.sv
module vxm_axis_split #(
   parameter int unsigned CW  = 8,
   parameter int unsigned SCW = 4
) (
   input  logic [CW-1:0]      coord,
   output logic [CW-SCW-1:0]  sc,
   output logic [SCW-2:0]     sv,
   output logic               odd,
   output logic               at_far
);
   always_comb begin
      sc     = coord[CW-1:SCW];
      sv     = coord[SCW-1:1];
      odd    = coord[0];
      at_far = &coord[SCW-1:0];
   end
endmodule

// File: rtl/vxm_owner_index.sv
module vxm_owner_index #(
   parameter int unsigned SCCW = 4,
   parameter int unsigned PW   = 4
) (
   input  logic [SCCW-1:0]        xs,
   input  logic [SCCW-1:0]        ys,
   input  logic [SCCW-1:0]        zs,
   input  logic [PW-1:0]          node,
   output logic                   owned,
   output logic [3*SCCW-PW-1:0]   lsn
);
   logic [SCCW+1:0]   sum;
   logic [3*SCCW-1:0] linear;

   always_comb begin
      sum    = {2'b00, xs} + {2'b00, ys} + {2'b00, zs};
      owned  = (sum[PW-1:0] == node);
      linear = {zs, ys, xs};
      lsn    = linear[3*SCCW-1:PW];
   end
endmodule

// File: rtl/vxm_bank_assemble.sv
module vxm_bank_assemble #(
   parameter int unsigned LW   = 3,
   parameter int unsigned LSNW = 8,
   parameter int unsigned AW   = LSNW + 3*LW
) (
   input  logic [LSNW-1:0]       lsn,
   input  logic [2:0][LW-1:0]    sv_lo,
   input  logic [2:0][LW-1:0]    sv_hi,
   input  logic [2:0]            odd,
   output logic [7:0][AW-1:0]    addr,
   output logic [7:0][2:0]       slot
);
   for (genvar b = 0; b < 8; b++) begin : g_bank
      logic [2:0][LW-1:0] fld;
      for (genvar a = 0; a < 3; a++) begin : g_axis
         localparam bit PAR = ((b >> a) & 1) != 0;
         if (PAR) begin : g_par1
            assign fld[a]     = sv_lo[a];
            assign slot[b][a] = ~odd[a];
         end else begin : g_par0
            assign fld[a]     = odd[a] ? sv_hi[a] : sv_lo[a];
            assign slot[b][a] = odd[a];
         end
      end
      assign addr[b] = {lsn, fld[2], fld[1], fld[0]};
   end
endmodule

// File: rtl/vx_octet_mapper.sv
module vx_octet_mapper #(
   parameter int unsigned VOL_EDGE = 256,
   parameter int unsigned NPROC    = 16,
   parameter int unsigned ILV      = 1,
   localparam int unsigned CW      = vxm_pkg::vxm_log2(VOL_EDGE),
   localparam int unsigned PW      = vxm_pkg::vxm_log2(NPROC),
   localparam int unsigned SC_EDGE = VOL_EDGE / (NPROC * ILV),
   localparam int unsigned SCW     = vxm_pkg::vxm_log2(SC_EDGE),
   localparam int unsigned SCCW    = CW - SCW,
   localparam int unsigned LW      = SCW - 1,
   localparam int unsigned LSNW    = 3*SCCW - PW,
   localparam int unsigned AW      = LSNW + 3*LW
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   in_vld,
   input  logic [CW-1:0]          base_x,
   input  logic [CW-1:0]          base_y,
   input  logic [CW-1:0]          base_z,
   input  logic [PW-1:0]          node_id,
   output logic                   out_vld,
   output logic                   out_err,
   output logic [7:0][AW-1:0]     bank_addr,
   output logic [7:0][2:0]        bank_slot
);
   if (!vxm_pkg::vxm_is_pow2(VOL_EDGE)) begin : g_bad_vol
      $error("VOL_EDGE must be a power of two");
   end
   if (!vxm_pkg::vxm_is_pow2(NPROC) || NPROC < 2) begin : g_bad_np
      $error("NPROC must be a power of two, at least 2");
   end
   if (!vxm_pkg::vxm_is_pow2(ILV)) begin : g_bad_ilv
      $error("ILV must be a power of two");
   end
   if (SC_EDGE < 4 || VOL_EDGE % (NPROC * ILV) != 0) begin : g_bad_sc
      $error("subcube edge must divide the volume and be at least 4");
   end

   // stage 1: per-axis split
   logic [2:0][CW-1:0]   coord;
   logic [2:0][SCCW-1:0] sc_c;
   logic [2:0][LW-1:0]   sv_c;
   logic [2:0]           odd_c, far_c;

   assign coord = {base_z, base_y, base_x};

   for (genvar a = 0; a < 3; a++) begin : g_split
      vxm_axis_split #(.CW(CW), .SCW(SCW)) u_split (
         .coord (coord[a]),
         .sc    (sc_c[a]),
         .sv    (sv_c[a]),
         .odd   (odd_c[a]),
         .at_far(far_c[a])
      );
   end

   logic                 s1_vld;
   logic [2:0][SCCW-1:0] s1_sc;
   logic [2:0][LW-1:0]   s1_sv;
   logic [2:0]           s1_odd, s1_far;
   logic [PW-1:0]        s1_node;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_vld <= 1'b0;
      end else begin
         s1_vld <= in_vld;
      end
      s1_sc   <= sc_c;
      s1_sv   <= sv_c;
      s1_odd  <= odd_c;
      s1_far  <= far_c;
      s1_node <= node_id;
   end

   // stage 2: ownership and local subcube number
   logic            owned_c;
   logic [LSNW-1:0] lsn_c;

   vxm_owner_index #(.SCCW(SCCW), .PW(PW)) u_owner (
      .xs   (s1_sc[0]),
      .ys   (s1_sc[1]),
      .zs   (s1_sc[2]),
      .node (s1_node),
      .owned(owned_c),
      .lsn  (lsn_c)
   );

   logic               s2_vld, s2_err;
   logic [LSNW-1:0]    s2_lsn;
   logic [2:0][LW-1:0] s2_lo, s2_hi;
   logic [2:0]         s2_odd;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_vld <= 1'b0;
         s2_err <= 1'b0;
      end else begin
         s2_vld <= s1_vld;
         s2_err <= s1_vld & (~owned_c | (|(s1_odd & s1_far)));
      end
      s2_lsn <= lsn_c;
      s2_lo  <= s1_sv;
      s2_odd <= s1_odd;
      for (int a = 0; a < 3; a++) begin
         s2_hi[a] <= s1_sv[a] + LW'(1);
      end
   end

   // stage 3: per-bank address assembly
   logic [7:0][AW-1:0] addr_c;
   logic [7:0][2:0]    slot_c;

   vxm_bank_assemble #(.LW(LW), .LSNW(LSNW), .AW(AW)) u_banks (
      .lsn  (s2_lsn),
      .sv_lo(s2_lo),
      .sv_hi(s2_hi),
      .odd  (s2_odd),
      .addr (addr_c),
      .slot (slot_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
         out_err <= 1'b0;
      end else begin
         out_vld <= s2_vld;
         out_err <= s2_err;
      end
      bank_addr <= addr_c;
      bank_slot <= slot_c;
   end
endmodule

// File: rtl/vx_octet_mapper_chk.sv
module vx_octet_mapper_chk #(
   parameter int unsigned VOL_EDGE = 256,
   parameter int unsigned NPROC    = 16,
   parameter int unsigned ILV      = 1,
   localparam int unsigned CW      = vxm_pkg::vxm_log2(VOL_EDGE),
   localparam int unsigned PW      = vxm_pkg::vxm_log2(NPROC),
   localparam int unsigned SCW     = vxm_pkg::vxm_log2(VOL_EDGE / (NPROC * ILV)),
   localparam int unsigned SCCW    = CW - SCW,
   localparam int unsigned LW      = SCW - 1,
   localparam int unsigned LSNW    = 3*SCCW - PW,
   localparam int unsigned AW      = LSNW + 3*LW
) (
   input logic                clk,
   input logic                rst,
   input logic                in_vld,
   input logic                out_vld,
   input logic                out_err,
   input logic [7:0][AW-1:0]  bank_addr,
   input logic [7:0][2:0]     bank_slot
);
   logic [1:0] since_rst;

   always_ff @(posedge clk) begin
      if (rst) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3)));

   assert_reset_R9: assert property (@(posedge clk)
      rst |=> (!out_vld && !out_err));

   assert_err_qual_R10: assert property (@(posedge clk) disable iff (rst)
      !out_vld |-> !out_err);

   for (genvar b = 1; b < 8; b++) begin : g_bank_chk
      assert_slot_map_R2: assert property (@(posedge clk) disable iff (rst)
         out_vld |-> ((bank_slot[b] ^ 3'(b)) == bank_slot[0]));
      assert_lsn_shared_R3: assert property (@(posedge clk) disable iff (rst)
         out_vld |-> (bank_addr[b][AW-1 -: LSNW] == bank_addr[0][AW-1 -: LSNW]));
   end

   for (genvar a = 0; a < 3; a++) begin : g_axis_chk
      assert_odd_step_R5: assert property (@(posedge clk) disable iff (rst)
         (out_vld && !out_err) |->
         ((bank_addr[0][a*LW +: LW] - bank_addr[1 << a][a*LW +: LW]) == LW'(bank_slot[0][a])));
   end
endmodule

bind vx_octet_mapper vx_octet_mapper_chk #(
   .VOL_EDGE(VOL_EDGE), .NPROC(NPROC), .ILV(ILV)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_vld   (in_vld),
   .out_vld  (out_vld),
   .out_err  (out_err),
   .bank_addr(bank_addr),
   .bank_slot(bank_slot)
);

// File: tb/sim_vx_octet_mapper.sv
module sim_vx_octet_mapper;
   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_vld = 1'b0;
   logic [7:0]        base_x = '0, base_y = '0, base_z = '0;
   logic [3:0]        node_id = '0;
   logic              out_vld, out_err;
   logic [7:0][16:0]  bank_addr;
   logic [7:0][2:0]   bank_slot;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   vx_octet_mapper u0 (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .base_x(base_x), .base_y(base_y), .base_z(base_z),
      .node_id(node_id), .out_vld(out_vld), .out_err(out_err),
      .bank_addr(bank_addr), .bank_slot(bank_slot)
   );

   // {exp_err, node, z, y, x}
   localparam int NV = 10;
   localparam logic [28:0] TBL [NV] = '{
      {1'b0, 4'd0,  8'd0,   8'd0,   8'd0  },
      {1'b0, 4'd1,  8'd0,   8'd0,   8'd17 },
      {1'b0, 4'd9,  8'd70,  8'd50,  8'd33 },
      {1'b1, 4'd1,  8'd2,   8'd2,   8'd31 },
      {1'b1, 4'd3,  8'd40,  8'd40,  8'd40 },
      {1'b0, 4'd11, 8'd145, 8'd99,  8'd201},
      {1'b0, 4'd13, 8'd254, 8'd254, 8'd254},
      {1'b0, 4'd0,  8'd12,  8'd13,  8'd14 },
      {1'b1, 4'd0,  8'd15,  8'd0,   8'd0  },
      {1'b1, 4'd15, 8'd0,   8'd0,   8'd255}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_addr(input int bx, input int by, input int bz, input int b);
      int xv, yv, zv, lsn;
      xv  = bx + ((b & 1) ^ (bx & 1));
      yv  = by + (((b >> 1) & 1) ^ (by & 1));
      zv  = bz + (((b >> 2) & 1) ^ (bz & 1));
      lsn = ((bx / 16) + (by / 16) * 16 + (bz / 16) * 256) / 16;
      return lsn * 512 + ((zv % 16) / 2) * 64 + ((yv % 16) / 2) * 8 + (xv % 16) / 2;
   endfunction

   task automatic check_vec(input int i);
      int bx, by, bz, e;
      bx = int'(TBL[i][7:0]);
      by = int'(TBL[i][15:8]);
      bz = int'(TBL[i][23:16]);
      e  = int'(TBL[i][28]);
      chk("R1 out_vld", int'(out_vld), 1);
      chk("R7/R8 out_err", int'(out_err), e);
      for (int b = 0; b < 8; b++) begin
         int sl;
         sl = (((b >> 2) & 1) ^ (bz & 1)) * 4 + (((b >> 1) & 1) ^ (by & 1)) * 2
              + ((b & 1) ^ (bx & 1));
         chk("R2 bank_slot", int'(bank_slot[b]), sl);
         if (e == 0)
            chk("R3/R4/R5/R6 bank_addr", int'(bank_addr[b]), exp_addr(bx, by, bz, b));
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 out_vld in reset", int'(out_vld), 0);
      chk("R9 out_err in reset", int'(out_err), 0);
      rst = 1'b0;

      // table walk, one request per cycle, results three edges later (R1)
      for (int i = 0; i < NV + 3; i++) begin
         @(negedge clk);
         if (i >= 3) check_vec(i - 3);
         if (i < NV) begin
            in_vld  = 1'b1;
            base_x  = TBL[i][7:0];
            base_y  = TBL[i][15:8];
            base_z  = TBL[i][23:16];
            node_id = TBL[i][27:24];
         end else begin
            in_vld = 1'b0;
         end
      end

      // R1: isolated request, valid for exactly one cycle three edges later
      @(negedge clk);
      in_vld = 1'b1; base_x = 8'd3; base_y = 8'd5; base_z = 8'd7; node_id = 4'd0;
      @(negedge clk);
      in_vld = 1'b0;
      chk("R1 not early (1)", int'(out_vld), 0);
      @(negedge clk);
      chk("R1 not early (2)", int'(out_vld), 0);
      @(negedge clk);
      chk("R1 due on third edge", int'(out_vld), 1);
      chk("R5 odd x step bank0", int'(bank_addr[0][2:0]), 2);
      chk("R5 odd x base bank1", int'(bank_addr[1][2:0]), 1);
      chk("R5 odd z step bank0", int'(bank_addr[0][8:6]), 4);
      @(negedge clk);
      chk("R1 one cycle only", int'(out_vld), 0);
      chk("R10 no err without vld", int'(out_err), 0);

      // R9: reset drops requests in flight (erroring ones too)
      in_vld = 1'b1; base_x = 8'd40; base_y = 8'd40; base_z = 8'd40; node_id = 4'd0;
      @(negedge clk);
      @(negedge clk);
      in_vld = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R9 out_vld after reset", int'(out_vld), 0);
      chk("R9 out_err after reset", int'(out_err), 0);
      @(negedge clk);
      chk("R9 in-flight dropped (1)", int'(out_vld), 0);
      @(negedge clk);
      chk("R9 in-flight dropped (2)", int'(out_vld), 0);
      chk("R10 err quiet", int'(out_err), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule